// File: doc/BRIEF.md
# Pitched Rectangle Copy Command Splitter

This block takes one request to move a rectangle between two linear (pitched) surfaces and breaks it into a series of memory-to-memory copy commands for a downstream copy engine. Each copy command names a source offset, a destination offset, both pitches, a line length in bytes and a line count. The line count of one command is capped. Between chunks the offsets move forward by whole lines. After every copy command two fixed beats follow that must never be dropped: a no-op, then a write of zero to the engine's output-offset register.

A second mode copies a flat byte range. The size is cut into full pages, sent as page-pitched commands under the same line cap, plus one single-line command for any leftover bytes. Requests arrive on a valid/ready handshake. Commands leave as beats on a valid/ready stream. The block holds every output steady while the stream is stalled, and takes no new request until the last fence beat of the current one has been accepted. Done and error are plain one-cycle pulses.

Top module: `rect_copy_splitter`

## Requirements
- R1: In rectangle mode the first copy command's source offset is source base + source y0 × source pitch + source x0 × source bytes-per-pixel (modulo 2^OFF_W). The destination offset is formed the same way from the destination fields.
- R2: In rectangle mode every copy command carries line length = (destination x1 − destination x0) × source bytes-per-pixel. Its source and destination pitch fields equal the request pitches.
- R3: Every copy command carries between 1 and MAX_LINES lines. Each one takes min(remaining, MAX_LINES), and the counts of a request sum to its height (or page count).
- R4: After each copy command the next one's source offset has grown by source pitch × lines just issued, and its destination offset by destination pitch × those lines.
- R5: Beat index 0 is a copy command, 1 a no-op and 2 the fence. Every copy beat is followed by a no-op beat and then a fence beat, and on beats 1 and 2 all data fields are zero.
- R6: In flat mode (req_flat=1) the size is split into pages of 2^PAGE_SHIFT bytes. Page commands use that value for both pitches and the line length, start at the two bases, and advance both offsets by page size × lines.
- R7: A flat remainder below one page goes out last as one command with one line, whose pitches and length all equal the remainder. No such command is emitted for a zero remainder.
- R8: A rectangle request with a zero pitch on either side, or with unequal source and destination extents in x or in y, raises err for one cycle. It emits no beat and no done, and the block returns to accepting requests.
- R9: A rectangle of height zero or a flat range of size zero emits no beat. Done pulses in the cycle after acceptance.
- R10: While cmd_valid is high and cmd_ready low, every command output holds its value.
- R11: req_ready is low from acceptance until the last fence beat has been taken. Done pulses for exactly the cycle after that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_flat | input | 1 | 1: flat byte range, 0: rectangle |
| req_src_base | input | OFF_W | Source base offset |
| req_dst_base | input | OFF_W | Destination base offset |
| req_src_pitch | input | PITCH_W | Source pitch in bytes (0 = not pitched) |
| req_dst_pitch | input | PITCH_W | Destination pitch in bytes (0 = not pitched) |
| req_src_bpp | input | BPP_W | Source bytes per pixel |
| req_dst_bpp | input | BPP_W | Destination bytes per pixel |
| req_src_x0 | input | COORD_W | Source left |
| req_src_y0 | input | COORD_W | Source top |
| req_src_x1 | input | COORD_W | Source right (exclusive) |
| req_src_y1 | input | COORD_W | Source bottom (exclusive) |
| req_dst_x0 | input | COORD_W | Destination left |
| req_dst_y0 | input | COORD_W | Destination top |
| req_dst_x1 | input | COORD_W | Destination right (exclusive) |
| req_dst_y1 | input | COORD_W | Destination bottom (exclusive) |
| req_size | input | OFF_W | Flat mode byte count |
| cmd_valid | output | 1 | Command beat present |
| cmd_ready | input | 1 | Consumer takes the beat |
| cmd_beat | output | 2 | Beat index: 0 copy, 1 no-op, 2 fence |
| cmd_src_off | output | OFF_W | Source offset |
| cmd_dst_off | output | OFF_W | Destination offset |
| cmd_src_pitch | output | OFF_W | Source pitch |
| cmd_dst_pitch | output | OFF_W | Destination pitch |
| cmd_line_len | output | OFF_W | Bytes per line |
| cmd_lines | output | LINES_W | Line count, LINES_W = clog2(MAX_LINES+1) |
| done | output | 1 | One-cycle pulse when a request has completed |
| err | output | 1 | One-cycle pulse for a rejected rectangle request |

## Verification
The bench builds the block with MAX_LINES = 5 and PAGE_SHIFT = 4 (16-byte pages), with the remaining widths at their defaults. A rectangle of a dozen lines or a flat range of a few hundred bytes therefore splits into several capped chunks. That brings chunk advance, the last short chunk and the page-then-tail order within reach in a handful of cycles, where the default cap of 2047 would need thousands of lines per test. The default widths keep the offset products and their wrap at 32 bits identical to a full build.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    BEAT_COPY  = 2'd0,
    BEAT_NOP   = 2'd1,
    BEAT_FENCE = 2'd2
  } beat_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/rcs_front.sv
module rcs_front #(
  parameter int OFF_W      = 32,
  parameter int COORD_W    = 16,
  parameter int PITCH_W    = 16,
  parameter int BPP_W      = 4,
  parameter int REM_W      = 20,
  parameter int PAGE_SHIFT = 12
) (
  input  logic               flat,
  input  logic [OFF_W-1:0]   src_base,
  input  logic [OFF_W-1:0]   dst_base,
  input  logic [PITCH_W-1:0] src_pitch,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [BPP_W-1:0]   src_bpp,
  input  logic [BPP_W-1:0]   dst_bpp,
  input  logic [COORD_W-1:0] src_x0,
  input  logic [COORD_W-1:0] src_y0,
  input  logic [COORD_W-1:0] src_x1,
  input  logic [COORD_W-1:0] src_y1,
  input  logic [COORD_W-1:0] dst_x0,
  input  logic [COORD_W-1:0] dst_y0,
  input  logic [COORD_W-1:0] dst_x1,
  input  logic [COORD_W-1:0] dst_y1,
  input  logic [OFF_W-1:0]   size,
  output logic               ok,
  output logic               empty,
  output logic [OFF_W-1:0]   st_src,
  output logic [OFF_W-1:0]   st_dst,
  output logic [OFF_W-1:0]   sp,
  output logic [OFF_W-1:0]   dp,
  output logic [OFF_W-1:0]   len,
  output logic [REM_W-1:0]   rem,
  output logic [OFF_W-1:0]   tail
);
  localparam logic [OFF_W-1:0] PAGE_BYTES = OFF_W'(1) << PAGE_SHIFT;
  localparam logic [OFF_W-1:0] PAGE_MASK  = PAGE_BYTES - OFF_W'(1);

  logic [COORD_W-1:0] sw, sh, dw, dh;
  logic [OFF_W-1:0]   rect_src, rect_dst, pages;

  always_comb begin
    sw = src_x1 - src_x0;
    sh = src_y1 - src_y0;
    dw = dst_x1 - dst_x0;
    dh = dst_y1 - dst_y0;
    rect_src = src_base + OFF_W'(src_y0) * OFF_W'(src_pitch)
                        + OFF_W'(src_x0) * OFF_W'(src_bpp);
    rect_dst = dst_base + OFF_W'(dst_y0) * OFF_W'(dst_pitch)
                        + OFF_W'(dst_x0) * OFF_W'(dst_bpp);
    pages    = size >> PAGE_SHIFT;
    if (flat) begin
      ok     = 1'b1;
      st_src = src_base;
      st_dst = dst_base;
      sp     = PAGE_BYTES;
      dp     = PAGE_BYTES;
      len    = PAGE_BYTES;
      rem    = REM_W'(pages);
      tail   = size & PAGE_MASK;
    end else begin
      ok     = (src_pitch != '0) && (dst_pitch != '0) && (sw == dw) && (sh == dh);
      st_src = rect_src;
      st_dst = rect_dst;
      sp     = OFF_W'(src_pitch);
      dp     = OFF_W'(dst_pitch);
      len    = OFF_W'(dw) * OFF_W'(src_bpp);
      rem    = REM_W'(dh);
      tail   = '0;
    end
    empty = (rem == '0) && (tail == '0);
  end
endmodule

// File: rtl/rcs_walker.sv
module rcs_walker
  import rcs_pkg::*;
#(
  parameter int OFF_W     = 32,
  parameter int REM_W     = 20,
  parameter int MAX_LINES = 2047,
  parameter int LINES_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               in_ok,
  input  logic               in_empty,
  input  logic [OFF_W-1:0]   in_src,
  input  logic [OFF_W-1:0]   in_dst,
  input  logic [OFF_W-1:0]   in_sp,
  input  logic [OFF_W-1:0]   in_dp,
  input  logic [OFF_W-1:0]   in_len,
  input  logic [REM_W-1:0]   in_rem,
  input  logic [OFF_W-1:0]   in_tail,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output beat_e              beat,
  output logic [OFF_W-1:0]   ch_src,
  output logic [OFF_W-1:0]   ch_dst,
  output logic [OFF_W-1:0]   ch_sp,
  output logic [OFF_W-1:0]   ch_dp,
  output logic [OFF_W-1:0]   ch_len,
  output logic [LINES_W-1:0] ch_lines,
  output logic               done,
  output logic               err
);
  state_e             state;
  beat_e              beat_r;
  logic [REM_W-1:0]   rem_r, rem_n;
  logic [OFF_W-1:0]   tail_r, tail_n;
  logic [OFF_W-1:0]   src_r, dst_r, sp_r, dp_r, len_r;
  logic               req_fire, cmd_fire, last_chunk;

  assign req_ready = (state == ST_IDLE);
  assign cmd_valid = (state == ST_RUN);
  assign req_fire  = req_valid && req_ready;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign beat      = beat_r;

  // chunk in flight: page/line chunks first, the single-line tail after them
  always_comb begin
    ch_src = src_r;
    ch_dst = dst_r;
    if (rem_r != '0) begin
      ch_lines = (rem_r > REM_W'(MAX_LINES)) ? LINES_W'(MAX_LINES) : LINES_W'(rem_r);
      ch_sp    = sp_r;
      ch_dp    = dp_r;
      ch_len   = len_r;
      rem_n    = rem_r - REM_W'(ch_lines);
      tail_n   = tail_r;
    end else begin
      ch_lines = LINES_W'(1);
      ch_sp    = tail_r;
      ch_dp    = tail_r;
      ch_len   = tail_r;
      rem_n    = '0;
      tail_n   = '0;
    end
    last_chunk = (rem_n == '0) && (tail_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      beat_r <= BEAT_COPY;
      rem_r  <= '0;
      tail_r <= '0;
      src_r  <= '0;
      dst_r  <= '0;
      sp_r   <= '0;
      dp_r   <= '0;
      len_r  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (state == ST_IDLE) begin
        if (req_fire) begin
          if (!in_ok) begin
            err <= 1'b1;
          end else if (in_empty) begin
            done <= 1'b1;
          end else begin
            state  <= ST_RUN;
            beat_r <= BEAT_COPY;
            rem_r  <= in_rem;
            tail_r <= in_tail;
            src_r  <= in_src;
            dst_r  <= in_dst;
            sp_r   <= in_sp;
            dp_r   <= in_dp;
            len_r  <= in_len;
          end
        end
      end else if (cmd_fire) begin
        case (beat_r)
          BEAT_COPY: beat_r <= BEAT_NOP;
          BEAT_NOP:  beat_r <= BEAT_FENCE;
          default: begin
            beat_r <= BEAT_COPY;
            rem_r  <= rem_n;
            tail_r <= tail_n;
            src_r  <= src_r + ch_sp * OFF_W'(ch_lines);
            dst_r  <= dst_r + ch_dp * OFF_W'(ch_lines);
            if (last_chunk) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(beat_r) && $stable(ch_src)
                                && $stable(ch_dst) && $stable(ch_lines) && $stable(ch_len));
  // R5
  copy_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && beat_r == BEAT_COPY |=> cmd_valid && beat_r == BEAT_NOP);
  // R5
  nop_then_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && beat_r == BEAT_NOP |=> cmd_valid && beat_r == BEAT_FENCE);
  // R3
  lines_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ch_lines != '0 && ch_lines <= LINES_W'(MAX_LINES));
  // R11
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
  // R8
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done && !cmd_valid);
endmodule

// File: rtl/rcs_beat_fmt.sv
module rcs_beat_fmt
  import rcs_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int LINES_W = 11
) (
  input  beat_e              beat,
  input  logic [OFF_W-1:0]   ch_src,
  input  logic [OFF_W-1:0]   ch_dst,
  input  logic [OFF_W-1:0]   ch_sp,
  input  logic [OFF_W-1:0]   ch_dp,
  input  logic [OFF_W-1:0]   ch_len,
  input  logic [LINES_W-1:0] ch_lines,
  output logic [1:0]         o_beat,
  output logic [OFF_W-1:0]   o_src,
  output logic [OFF_W-1:0]   o_dst,
  output logic [OFF_W-1:0]   o_sp,
  output logic [OFF_W-1:0]   o_dp,
  output logic [OFF_W-1:0]   o_len,
  output logic [LINES_W-1:0] o_lines
);
  logic is_copy;

  always_comb begin
    is_copy = (beat == BEAT_COPY);
    o_beat  = beat;
    o_src   = is_copy ? ch_src   : '0;
    o_dst   = is_copy ? ch_dst   : '0;
    o_sp    = is_copy ? ch_sp    : '0;
    o_dp    = is_copy ? ch_dp    : '0;
    o_len   = is_copy ? ch_len   : '0;
    o_lines = is_copy ? ch_lines : '0;
  end
endmodule

// File: rtl/rect_copy_splitter.sv
module rect_copy_splitter
  import rcs_pkg::*;
#(
  parameter int OFF_W      = 32,
  parameter int COORD_W    = 16,
  parameter int PITCH_W    = 16,
  parameter int BPP_W      = 4,
  parameter int MAX_LINES  = 2047,
  parameter int PAGE_SHIFT = 12,
  localparam int LINES_W   = $clog2(MAX_LINES + 1),
  localparam int REM_W     = ((OFF_W - PAGE_SHIFT) > COORD_W) ? (OFF_W - PAGE_SHIFT) : COORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_flat,
  input  logic [OFF_W-1:0]   req_src_base,
  input  logic [OFF_W-1:0]   req_dst_base,
  input  logic [PITCH_W-1:0] req_src_pitch,
  input  logic [PITCH_W-1:0] req_dst_pitch,
  input  logic [BPP_W-1:0]   req_src_bpp,
  input  logic [BPP_W-1:0]   req_dst_bpp,
  input  logic [COORD_W-1:0] req_src_x0,
  input  logic [COORD_W-1:0] req_src_y0,
  input  logic [COORD_W-1:0] req_src_x1,
  input  logic [COORD_W-1:0] req_src_y1,
  input  logic [COORD_W-1:0] req_dst_x0,
  input  logic [COORD_W-1:0] req_dst_y0,
  input  logic [COORD_W-1:0] req_dst_x1,
  input  logic [COORD_W-1:0] req_dst_y1,
  input  logic [OFF_W-1:0]   req_size,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [1:0]         cmd_beat,
  output logic [OFF_W-1:0]   cmd_src_off,
  output logic [OFF_W-1:0]   cmd_dst_off,
  output logic [OFF_W-1:0]   cmd_src_pitch,
  output logic [OFF_W-1:0]   cmd_dst_pitch,
  output logic [OFF_W-1:0]   cmd_line_len,
  output logic [LINES_W-1:0] cmd_lines,
  output logic               done,
  output logic               err
);
  logic               f_ok, f_empty;
  logic [OFF_W-1:0]   f_src, f_dst, f_sp, f_dp, f_len, f_tail;
  logic [REM_W-1:0]   f_rem;
  beat_e              w_beat;
  logic [OFF_W-1:0]   w_src, w_dst, w_sp, w_dp, w_len;
  logic [LINES_W-1:0] w_lines;

  rcs_front #(
    .OFF_W(OFF_W), .COORD_W(COORD_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W),
    .REM_W(REM_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) front_i (
    .flat(req_flat), .src_base(req_src_base), .dst_base(req_dst_base),
    .src_pitch(req_src_pitch), .dst_pitch(req_dst_pitch),
    .src_bpp(req_src_bpp), .dst_bpp(req_dst_bpp),
    .src_x0(req_src_x0), .src_y0(req_src_y0), .src_x1(req_src_x1), .src_y1(req_src_y1),
    .dst_x0(req_dst_x0), .dst_y0(req_dst_y0), .dst_x1(req_dst_x1), .dst_y1(req_dst_y1),
    .size(req_size), .ok(f_ok), .empty(f_empty), .st_src(f_src), .st_dst(f_dst),
    .sp(f_sp), .dp(f_dp), .len(f_len), .rem(f_rem), .tail(f_tail)
  );

  rcs_walker #(
    .OFF_W(OFF_W), .REM_W(REM_W), .MAX_LINES(MAX_LINES), .LINES_W(LINES_W)
  ) walker_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .in_ok(f_ok), .in_empty(f_empty), .in_src(f_src), .in_dst(f_dst),
    .in_sp(f_sp), .in_dp(f_dp), .in_len(f_len), .in_rem(f_rem), .in_tail(f_tail),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .beat(w_beat),
    .ch_src(w_src), .ch_dst(w_dst), .ch_sp(w_sp), .ch_dp(w_dp), .ch_len(w_len),
    .ch_lines(w_lines), .done(done), .err(err)
  );

  rcs_beat_fmt #(.OFF_W(OFF_W), .LINES_W(LINES_W)) fmt_i (
    .beat(w_beat), .ch_src(w_src), .ch_dst(w_dst), .ch_sp(w_sp), .ch_dp(w_dp),
    .ch_len(w_len), .ch_lines(w_lines), .o_beat(cmd_beat), .o_src(cmd_src_off),
    .o_dst(cmd_dst_off), .o_sp(cmd_src_pitch), .o_dp(cmd_dst_pitch),
    .o_len(cmd_line_len), .o_lines(cmd_lines)
  );

  // R5
  fence_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_beat != 2'd0 |-> cmd_lines == '0 && cmd_line_len == '0
                                      && cmd_src_off == '0 && cmd_dst_off == '0);
  // R5
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_beat != 2'd3);
endmodule

// File: tb/rect_copy_splitter_tb_top.sv
module rect_copy_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 5;
  localparam int PSH        = 4;
  localparam int PAGE       = 1 << PSH;
  localparam int LW         = $clog2(MAXL + 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_flat = 0, cmd_ready = 0;
  logic [31:0] src_base = 0, dst_base = 0, size = 0;
  logic [15:0] src_pitch = 0, dst_pitch = 0;
  logic [3:0]  src_bpp = 0, dst_bpp = 0;
  logic [15:0] sx0 = 0, sy0 = 0, sx1 = 0, sy1 = 0, dx0 = 0, dy0 = 0, dx1 = 0, dy1 = 0;
  logic req_ready, cmd_valid, done, err;
  logic [1:0]  cmd_beat;
  logic [31:0] c_src, c_dst, c_sp, c_dp, c_len;
  logic [LW-1:0] c_lines;

  int checks = 0, failures = 0;
  bit finished = 0;

  // captured beat
  logic [1:0]  g_beat;
  logic [31:0] g_src, g_dst, g_sp, g_dp, g_len;
  int          g_lines;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_copy_splitter #(.MAX_LINES(MAXL), .PAGE_SHIFT(PSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_flat(req_flat), .req_src_base(src_base), .req_dst_base(dst_base),
    .req_src_pitch(src_pitch), .req_dst_pitch(dst_pitch),
    .req_src_bpp(src_bpp), .req_dst_bpp(dst_bpp),
    .req_src_x0(sx0), .req_src_y0(sy0), .req_src_x1(sx1), .req_src_y1(sy1),
    .req_dst_x0(dx0), .req_dst_y0(dy0), .req_dst_x1(dx1), .req_dst_y1(dy1),
    .req_size(size), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_beat(cmd_beat),
    .cmd_src_off(c_src), .cmd_dst_off(c_dst), .cmd_src_pitch(c_sp),
    .cmd_dst_pitch(c_dp), .cmd_line_len(c_len), .cmd_lines(c_lines),
    .done(done), .err(err)
  );

  task automatic check(input bit cond, input string req, input string msg);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic get_beat();
    bit got = 0, stalled = 0;
    int waitc = 0;
    logic [1:0] pb; logic [31:0] ps; int pl;
    while (!got) begin
      @(negedge clk);
      if (stalled) begin
        check(cmd_valid && cmd_beat == pb && c_src == ps && int'(c_lines) == pl, "R10",
              $sformatf("stall hold: beat %0d src %0h lines %0d, expected %0d %0h %0d",
                        cmd_beat, c_src, c_lines, pb, ps, pl));
        stalled = 0;
      end
      if (cmd_valid) begin
        cmd_ready = ($urandom % 4) != 0;
        if (cmd_ready) begin
          g_beat = cmd_beat; g_src = c_src; g_dst = c_dst; g_sp = c_sp;
          g_dp = c_dp; g_len = c_len; g_lines = int'(c_lines);
          check(!req_ready, "R11", $sformatf("req_ready=%0d while busy, expected 0", req_ready));
          got = 1;
        end else begin
          stalled = 1; pb = cmd_beat; ps = c_src; pl = int'(c_lines);
        end
      end else cmd_ready = 0;
      waitc++;
      if (waitc > 200 && !got) begin
        check(0, "R11", "no beat arrived within 200 cycles, expected a beat");
        g_beat = 2'd3; got = 1;
      end
    end
  endtask

  task automatic expect_chunk(input logic [31:0] es, ed, esp, edp, elen, input int el,
                              input string tag);
    get_beat();
    check(g_beat == 0 && g_src == es && g_dst == ed && g_sp == esp && g_dp == edp
          && g_len == elen && g_lines == el, tag,
          $sformatf("copy beat=%0d src=%0h dst=%0h sp=%0h dp=%0h len=%0h lines=%0d, expected 0 %0h %0h %0h %0h %0h %0d",
                    g_beat, g_src, g_dst, g_sp, g_dp, g_len, g_lines, es, ed, esp, edp, elen, el));
    get_beat();
    check(g_beat == 1 && g_src == 0 && g_len == 0 && g_lines == 0, "R5",
          $sformatf("no-op beat=%0d len=%0h lines=%0d, expected 1 0 0", g_beat, g_len, g_lines));
    get_beat();
    check(g_beat == 2 && g_dst == 0 && g_len == 0 && g_lines == 0, "R5",
          $sformatf("fence beat=%0d dst=%0h lines=%0d, expected 2 0 0", g_beat, g_dst, g_lines));
  endtask

  // drive the request, return at the negedge after acceptance
  task automatic issue();
    @(negedge clk);
    check(req_ready, "R11", $sformatf("req_ready=%0d before request, expected 1", req_ready));
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_check();
    @(negedge clk);
    cmd_ready = 0;
    check(done && !cmd_valid && req_ready, "R11",
          $sformatf("after last fence done=%0d valid=%0d ready=%0d, expected 1 0 1",
                    done, cmd_valid, req_ready));
  endtask

  task automatic run_rect();
    logic [31:0] so, dso, ln, w, h;
    bit ok;
    int first = 1;
    w  = 32'(dx1 - dx0);
    h  = 32'(dy1 - dy0);
    ok = src_pitch != 0 && dst_pitch != 0 && (sx1 - sx0) == (dx1 - dx0) && (sy1 - sy0) == (dy1 - dy0);
    so = src_base + 32'(sy0) * 32'(src_pitch) + 32'(sx0) * 32'(src_bpp);
    dso = dst_base + 32'(dy0) * 32'(dst_pitch) + 32'(dx0) * 32'(dst_bpp);
    ln = w * 32'(src_bpp);
    req_flat = 0;
    issue();
    if (!ok) begin
      check(err && !done && !cmd_valid, "R8",
            $sformatf("reject err=%0d done=%0d valid=%0d, expected 1 0 0", err, done, cmd_valid));
      @(negedge clk);
      check(!cmd_valid && req_ready, "R8",
            $sformatf("after reject valid=%0d ready=%0d, expected 0 1", cmd_valid, req_ready));
    end else if (h == 0) begin
      check(done && !cmd_valid && !err, "R9",
            $sformatf("empty rect done=%0d valid=%0d err=%0d, expected 1 0 0", done, cmd_valid, err));
    end else begin
      while (h != 0) begin
        int l = (h > MAXL) ? MAXL : int'(h);
        expect_chunk(so, dso, 32'(src_pitch), 32'(dst_pitch), ln, l,
                     first ? "R1" : "R4");
        first = 0;
        h  -= 32'(l);
        so += 32'(src_pitch) * 32'(l);
        dso += 32'(dst_pitch) * 32'(l);
      end
      finish_check();
    end
  endtask

  task automatic run_flat();
    logic [31:0] so, dso, pages, tl;
    so = src_base; dso = dst_base;
    pages = size >> PSH;
    tl = size & 32'(PAGE - 1);
    req_flat = 1;
    issue();
    if (pages == 0 && tl == 0) begin
      check(done && !cmd_valid, "R9",
            $sformatf("empty range done=%0d valid=%0d, expected 1 0", done, cmd_valid));
    end else begin
      while (pages != 0) begin
        int l = (pages > MAXL) ? MAXL : int'(pages);
        expect_chunk(so, dso, PAGE, PAGE, PAGE, l, "R6");
        pages -= 32'(l);
        so += 32'(PAGE * l);
        dso += 32'(PAGE * l);
      end
      if (tl != 0) expect_chunk(so, dso, tl, tl, tl, 1, "R7");
      finish_check();
    end
    req_flat = 0;
  endtask

  task automatic set_rect(input int w, h, input bit mism);
    src_base = $urandom % 4096; dst_base = $urandom % 4096;
    src_pitch = 16'(64 + $urandom % 256); dst_pitch = 16'(64 + $urandom % 256);
    src_bpp = 4'(1 + $urandom % 4); dst_bpp = 4'(1 + $urandom % 4);
    sx0 = 16'($urandom % 40); sy0 = 16'($urandom % 40);
    dx0 = 16'($urandom % 40); dy0 = 16'($urandom % 40);
    sx1 = sx0 + 16'(w); sy1 = sy0 + 16'(h);
    dx1 = dx0 + 16'(w); dy1 = dy0 + 16'(h);
    if (mism) sx1 = sx1 + 16'd1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL R11: watchdog expired, run incomplete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !cmd_valid && !done && !err, "R11",
          $sformatf("reset ready=%0d valid=%0d done=%0d err=%0d, expected 1 0 0 0",
                    req_ready, cmd_valid, done, err));
    // directed: R2 single chunk, R3 exact cap, cap+1, multi
    set_rect(7, 3, 0);  run_rect();   // R2
    set_rect(4, 5, 0);  run_rect();   // R3 exactly the cap
    set_rect(9, 11, 0); run_rect();   // R3 R4 three chunks
    set_rect(6, 0, 0);  run_rect();   // R9 zero height
    set_rect(5, 5, 1);  run_rect();   // R8 width mismatch
    set_rect(5, 5, 0); sy1 = sy1 + 16'd2; run_rect(); // R8 height mismatch
    set_rect(5, 5, 0); src_pitch = 0; run_rect();     // R8 source not pitched
    set_rect(5, 5, 0); dst_pitch = 0; run_rect();     // R8 destination not pitched
    // directed flat
    src_base = 32'h100; dst_base = 32'h9000;
    size = 0;               run_flat();  // R9
    size = 5;               run_flat();  // R7 tail only
    size = PAGE;            run_flat();  // R7 no tail
    size = PAGE * 12 + 9;   run_flat();  // R6 R7 capped pages plus tail
    size = PAGE * 5;        run_flat();  // R6 exactly cap
    // random mix
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 3 == 0) begin
        src_base = $urandom; dst_base = $urandom;
        size = $urandom % 300;
        run_flat();
      end else begin
        set_rect(int'($urandom % 20), int'($urandom % 18), ($urandom % 6) == 0);
        run_rect();
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule